// File: doc/BRIEF.md
# Multithreaded Commit Slot Thread Arbiter

This block decides, for one commit slot of a multithreaded out-of-order core, which hardware thread may retire the instruction at the head of its reorder buffer. Each thread reports a 3-bit commit status, whether its head instruction is ready, whether its buffer is empty, and the sequence number of its head instruction. A static policy input selects between a rotating priority list and an oldest-head-first comparison. The block answers combinationally in the same cycle with a valid flag and a thread index.

Under the rotating policy the block keeps an ordered list of thread indices. A thread that is granted, and whose grant the commit logic actually uses, moves to the back of that list at the next clock edge. Under the oldest-first policies the list is left alone. When the core is built with a single thread, that thread is returned whenever its status permits, without any arbitration.

Top module: `commit_thread_arbiter`

## Requirements
- R1: A thread may be granted only when its status code is 0 (running), 1 (idle) or 4 (fetch trap pending); codes 2 (squashing), 3 (trap pending) and 5 to 7 are never granted. Status of thread i sits in thrStatus[3i+2:3i].
- R2: With policySel = 1 (rotating), the grant goes to the first thread in priority-list order that is eligible, has its head ready and has a non-empty buffer.
- R3: Under the rotating policy, when grantValid and grantTaken are both 1 at a clock edge, the granted thread moves to the tail of the list and the threads behind it move up one place; without that, the list keeps its order.
- R4: With policySel = 2 (oldest-ready), the grant goes to the eligible, ready, non-empty thread whose head sequence number (headSeq[i*SEQ_W +: SEQ_W]) is smallest, compared unsigned.
- R5: policySel = 0 (aggressive) and policySel = 3 (reserved) select exactly as the oldest-ready policy does.
- R6: When no thread qualifies, grantValid is 0 and grantTid is 0, and grantTaken has no effect.
- R7: Reset (rstN low, asynchronous) restores the priority list to ascending order 0, 1, ..., N-1.
- R8: A grant taken while an oldest-first policy is selected leaves the priority list unchanged.
- R9: With NUM_THREADS = 1, thread 0 is granted whenever its status is eligible, regardless of head-ready and buffer-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| policySel | input | 2 | 0 aggressive, 1 rotating, 2 oldest-ready, 3 reserved (oldest-ready) |
| thrStatus | input | 3*NUM_THREADS | Per-thread commit status codes |
| headReady | input | NUM_THREADS | Head instruction of each thread is ready to commit |
| robEmpty | input | NUM_THREADS | Reorder buffer of each thread holds nothing |
| headSeq | input | SEQ_W*NUM_THREADS | Sequence number of each thread's head instruction |
| grantTaken | input | 1 | The commit logic consumed this cycle's grant |
| grantValid | output | 1 | A thread is granted this slot |
| grantTid | output | max(1,clog2(NUM_THREADS)) | Granted thread index, 0 when none |

## Verification
The list rotation caused by a consumed grant and the selection for the following slot meet at the same clock edge: the new selection must already see the rotated list while eligibility has changed underneath it. The bench provokes this by taking a grant for one thread and, in the very next cycle, putting another thread into a squashing or trap state, then judging both the immediate grant and the order revealed by later rotating-policy grants. Policy switches between consecutive slots are used the same way to show that oldest-first grants leave the list as it was.

// File: rtl/commit_arb_pkg.sv
`timescale 1ns/1ps
package commit_arb_pkg;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_IDLE    = 3'd1,
    ST_SQUASH  = 3'd2,
    ST_TRAP    = 3'd3,
    ST_FTRAP   = 3'd4
  } thr_status_e;

  typedef enum logic [1:0] {
    POL_GREEDY = 2'd0,
    POL_ROTATE = 2'd1,
    POL_OLDEST = 2'd2,
    POL_RSVD   = 2'd3
  } policy_e;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic useRotate;
    logic shiftList;
  } arb_strobe_t;

  function automatic logic statusEligible(input logic [2:0] code);
    return (code == ST_RUN) || (code == ST_IDLE) || (code == ST_FTRAP);
  endfunction

endpackage

// File: rtl/commit_arb_ctl.sv
`timescale 1ns/1ps
module commit_arb_ctl
  import commit_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  policySel,
  input  logic        grantValid,
  input  logic        grantTaken,
  output arb_strobe_t strobe
);

  logic rotateSel;

  assign rotateSel        = (policySel == POL_ROTATE);
  assign strobe.useRotate = rotateSel;
  assign strobe.shiftList = rotateSel && grantValid && grantTaken;

  // R8: a list shift never happens while an oldest-first policy is active
  a_r8_no_shift_oldest: assert property (@(posedge clk) disable iff (!rstN)
    (policySel != POL_ROTATE) |-> !strobe.shiftList);

  // R6: nothing to consume means no shift
  a_r6_no_shift_idle: assert property (@(posedge clk) disable iff (!rstN)
    !grantValid |-> !strobe.shiftList);

endmodule

// File: rtl/commit_arb_dp.sv
`timescale 1ns/1ps
module commit_arb_dp
  import commit_arb_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 16,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  arb_strobe_t                  strobe,
  input  logic [NUM_THREADS*3-1:0]     thrStatus,
  input  logic [NUM_THREADS-1:0]       headReady,
  input  logic [NUM_THREADS-1:0]       robEmpty,
  input  logic [NUM_THREADS*SEQ_W-1:0] headSeq,
  output logic                         grantValid,
  output logic [TID_W-1:0]             grantTid
);

  logic [NUM_THREADS-1:0] eligible;
  logic [NUM_THREADS-1:0] qualify;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_elig
    assign eligible[t] = statusEligible(thrStatus[3*t +: 3]);
    assign qualify[t]  = eligible[t] && headReady[t] && !robEmpty[t];
  end

  if (NUM_THREADS == 1) begin : g_single
    // R9: single thread bypasses arbitration
    assign grantValid = eligible[0];
    assign grantTid   = '0;
  end else begin : g_multi
    logic [NUM_THREADS-1:0][TID_W-1:0] prioList;
    logic                              rrValid;
    logic [TID_W-1:0]                  rrTid;
    logic [TID_W-1:0]                  rrPos;
    logic                              oldValid;
    logic [TID_W-1:0]                  oldTid;
    logic [SEQ_W-1:0]                  oldSeq;

    // Rotating policy: scan the priority list front to back
    always_comb begin
      rrValid = 1'b0;
      rrTid   = '0;
      rrPos   = '0;
      for (int k = 0; k < NUM_THREADS; k++) begin
        if (!rrValid && qualify[prioList[k]]) begin
          rrValid = 1'b1;
          rrTid   = prioList[k];
          rrPos   = TID_W'(k);
        end
      end
    end

    // Oldest-ready policy: unsigned minimum of head sequence numbers
    always_comb begin
      oldValid = 1'b0;
      oldTid   = '0;
      oldSeq   = '0;
      for (int i = 0; i < NUM_THREADS; i++) begin
        if (qualify[i] && (!oldValid || headSeq[i*SEQ_W +: SEQ_W] < oldSeq)) begin
          oldValid = 1'b1;
          oldTid   = TID_W'(i);
          oldSeq   = headSeq[i*SEQ_W +: SEQ_W];
        end
      end
    end

    always_comb begin
      if (strobe.useRotate) begin
        grantValid = rrValid;
        grantTid   = rrValid ? rrTid : '0;
      end else begin
        grantValid = oldValid;
        grantTid   = oldValid ? oldTid : '0;
      end
    end

    // Priority list: shift up behind the granted entry, append it at the tail
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int k = 0; k < NUM_THREADS; k++) prioList[k] <= TID_W'(k);
      end else if (strobe.shiftList) begin
        for (int k = 0; k < NUM_THREADS - 1; k++) begin
          if (TID_W'(k) >= rrPos) prioList[k] <= prioList[k+1];
        end
        prioList[NUM_THREADS-1] <= rrTid;
      end
    end

    // Checking aids
    logic [NUM_THREADS-1:0] seenMask;
    always_comb begin
      seenMask = '0;
      for (int k = 0; k < NUM_THREADS; k++) seenMask[prioList[k]] = 1'b1;
    end

    a_r6_none_zero: assert property (@(posedge clk) disable iff (!rstN)
      !grantValid |-> (grantTid == '0));

    a_r1_only_eligible: assert property (@(posedge clk) disable iff (!rstN)
      grantValid |-> statusEligible(thrStatus[3*grantTid +: 3]));

    a_r4_head_present: assert property (@(posedge clk) disable iff (!rstN)
      grantValid |-> (headReady[grantTid] && !robEmpty[grantTid]));

    a_r3_to_tail: assert property (@(posedge clk) disable iff (!rstN)
      strobe.shiftList |=> (prioList[NUM_THREADS-1] == $past(grantTid)));

    a_r8_list_hold: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.shiftList |=> $stable(prioList));

    a_r7_permutation: assert property (@(posedge clk) disable iff (!rstN)
      $countones(seenMask) == NUM_THREADS);
  end

endmodule

// File: rtl/commit_thread_arbiter.sv
`timescale 1ns/1ps
module commit_thread_arbiter
  import commit_arb_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 16,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [1:0]                   policySel,
  input  logic [NUM_THREADS*3-1:0]     thrStatus,
  input  logic [NUM_THREADS-1:0]       headReady,
  input  logic [NUM_THREADS-1:0]       robEmpty,
  input  logic [NUM_THREADS*SEQ_W-1:0] headSeq,
  input  logic                         grantTaken,
  output logic                         grantValid,
  output logic [TID_W-1:0]             grantTid
);

  arb_strobe_t strobe;

  commit_arb_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .policySel  (policySel),
    .grantValid (grantValid),
    .grantTaken (grantTaken),
    .strobe     (strobe)
  );

  commit_arb_dp #(
    .NUM_THREADS (NUM_THREADS),
    .SEQ_W       (SEQ_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .thrStatus  (thrStatus),
    .headReady  (headReady),
    .robEmpty   (robEmpty),
    .headSeq    (headSeq),
    .grantValid (grantValid),
    .grantTid   (grantTid)
  );

endmodule

// File: tb/tb_commit_thread_arbiter.sv
`timescale 1ns/1ps
module tb_commit_thread_arbiter;

  localparam int HALF = 10; // 50 MHz

  typedef struct packed {
    logic [1:0]  pol;
    logic [2:0]  s3, s2, s1, s0;
    logic [3:0]  rdy;
    logic [3:0]  emp;
    logic [15:0] q3, q2, q1, q0;
    logic        take;
    logic        expV;
    logic [1:0]  expT;
    logic [3:0]  req;
  } vec_t;

  // List starts 0,1,2,3. Comments give the list after each row.
  localparam vec_t VECS [16] = '{
    '{2'd1, 3'd0,3'd0,3'd0,3'd0, 4'hF, 4'h0, 16'd0,16'd0,16'd0,16'd0, 1'b1, 1'b1, 2'd0, 4'd2}, // R2 ->1,2,3,0
    '{2'd1, 3'd0,3'd0,3'd0,3'd0, 4'hF, 4'h0, 16'd0,16'd0,16'd0,16'd0, 1'b1, 1'b1, 2'd1, 4'd3}, // R3 ->2,3,0,1
    '{2'd1, 3'd0,3'd0,3'd0,3'd0, 4'hB, 4'h0, 16'd0,16'd0,16'd0,16'd0, 1'b0, 1'b1, 2'd3, 4'd2}, // R2 skip not ready
    '{2'd1, 3'd0,3'd2,3'd0,3'd0, 4'hF, 4'h0, 16'd0,16'd0,16'd0,16'd0, 1'b1, 1'b1, 2'd3, 4'd1}, // R1 ->2,0,1,3
    '{2'd1, 3'd0,3'd0,3'd0,3'd0, 4'hF, 4'h0, 16'd0,16'd0,16'd0,16'd0, 1'b0, 1'b1, 2'd2, 4'd3}, // R3
    '{2'd1, 3'd0,3'd3,3'd0,3'd4, 4'hF, 4'h0, 16'd0,16'd0,16'd0,16'd0, 1'b1, 1'b1, 2'd0, 4'd1}, // R1 ->2,1,3,0
    '{2'd1, 3'd0,3'd0,3'd0,3'd0, 4'hF, 4'h4, 16'd0,16'd0,16'd0,16'd0, 1'b0, 1'b1, 2'd1, 4'd2}, // R2 skip empty
    '{2'd2, 3'd0,3'd0,3'd0,3'd0, 4'hF, 4'h0, 16'd35,16'd50,16'd30,16'd40, 1'b1, 1'b1, 2'd1, 4'd4}, // R4
    '{2'd2, 3'd0,3'd0,3'd0,3'd0, 4'hD, 4'h0, 16'd35,16'd50,16'd30,16'd40, 1'b1, 1'b1, 2'd3, 4'd4}, // R4
    '{2'd0, 3'd2,3'd0,3'd0,3'd0, 4'hD, 4'h0, 16'd35,16'd50,16'd30,16'd40, 1'b1, 1'b1, 2'd0, 4'd5}, // R5
    '{2'd3, 3'd0,3'd0,3'd0,3'd0, 4'h5, 4'h0, 16'd1,16'h7FFF,16'd2,16'h8000, 1'b1, 1'b1, 2'd2, 4'd5}, // R5 unsigned
    '{2'd1, 3'd0,3'd0,3'd0,3'd0, 4'hF, 4'h0, 16'd0,16'd0,16'd0,16'd0, 1'b0, 1'b1, 2'd2, 4'd8}, // R8 list kept
    '{2'd1, 3'd0,3'd0,3'd0,3'd0, 4'h0, 4'h0, 16'd0,16'd0,16'd0,16'd0, 1'b1, 1'b0, 2'd0, 4'd6}, // R6
    '{2'd1, 3'd0,3'd0,3'd0,3'd0, 4'hF, 4'h0, 16'd0,16'd0,16'd0,16'd0, 1'b0, 1'b1, 2'd2, 4'd6}, // R6 take ignored
    '{2'd2, 3'd0,3'd0,3'd0,3'd0, 4'hF, 4'hF, 16'd0,16'd0,16'd0,16'd0, 1'b0, 1'b0, 2'd0, 4'd6}, // R6 all empty
    '{2'd1, 3'd3,3'd7,3'd6,3'd5, 4'hF, 4'h0, 16'd0,16'd0,16'd0,16'd0, 1'b0, 1'b0, 2'd0, 4'd1}  // R1 none eligible
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  policySel = 2'd1;
  logic [11:0] thrStatus = '0;
  logic [3:0]  headReady = '0;
  logic [3:0]  robEmpty = '0;
  logic [63:0] headSeq = '0;
  logic        grantTaken = 1'b0;
  logic        grantValid;
  logic [1:0]  grantTid;

  logic [2:0]  oneStatus = 3'd0;
  logic        oneReady = 1'b0;
  logic        oneEmpty = 1'b1;
  logic        oneValid;
  logic        oneTid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #HALF clk = ~clk;

  commit_thread_arbiter #(.NUM_THREADS(4), .SEQ_W(16)) dut (
    .clk(clk), .rstN(rstN), .policySel(policySel), .thrStatus(thrStatus),
    .headReady(headReady), .robEmpty(robEmpty), .headSeq(headSeq),
    .grantTaken(grantTaken), .grantValid(grantValid), .grantTid(grantTid)
  );

  commit_thread_arbiter #(.NUM_THREADS(1), .SEQ_W(16)) dutOne (
    .clk(clk), .rstN(rstN), .policySel(2'd1), .thrStatus(oneStatus),
    .headReady(oneReady), .robEmpty(oneEmpty), .headSeq(16'd0),
    .grantTaken(1'b0), .grantValid(oneValid), .grantTid(oneTid)
  );

  task automatic check(input string tag, input logic v, input logic [1:0] t,
                       input logic ev, input logic [1:0] et);
    checks++;
    if (v !== ev || t !== et) begin
      fails++;
      $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d", tag, v, t, ev, et);
    end
  endtask

  task automatic allRun(input logic [1:0] pol, input logic [3:0] rdy);
    policySel = pol;
    thrStatus = '0;
    headReady = rdy;
    robEmpty  = '0;
  endtask

  initial begin
    // R7: list is ascending while and after reset
    allRun(2'd1, 4'hF);
    #3;
    check("R7 in reset", grantValid, grantTid, 1'b1, 2'd0);
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    #2;
    check("R7 after reset", grantValid, grantTid, 1'b1, 2'd0);

    // Table walk
    for (int n = 0; n < 16; n++) begin
      @(negedge clk);
      policySel  = VECS[n].pol;
      thrStatus  = {VECS[n].s3, VECS[n].s2, VECS[n].s1, VECS[n].s0};
      headReady  = VECS[n].rdy;
      robEmpty   = VECS[n].emp;
      headSeq    = {VECS[n].q3, VECS[n].q2, VECS[n].q1, VECS[n].q0};
      grantTaken = VECS[n].take;
      #2;
      check($sformatf("R%0d vector %0d", VECS[n].req, n), grantValid, grantTid,
            VECS[n].expV, VECS[n].expT);
    end

    // R3 with same-cycle eligibility change: list is 2,1,3,0
    @(negedge clk);
    allRun(2'd1, 4'hF); grantTaken = 1'b1;
    #2; check("R3 take 2", grantValid, grantTid, 1'b1, 2'd2);   // -> 1,3,0,2
    @(negedge clk);
    thrStatus = {3'd0, 3'd0, 3'd2, 3'd0}; grantTaken = 1'b1;      // thread 1 squashing
    #2; check("R1 squash next slot", grantValid, grantTid, 1'b1, 2'd3); // -> 1,0,2,3
    @(negedge clk);
    thrStatus = '0; grantTaken = 1'b0;
    #2; check("R3 order after rotate", grantValid, grantTid, 1'b1, 2'd1);
    headReady = 4'b1101;
    #2; check("R3 second in list", grantValid, grantTid, 1'b1, 2'd0);

    // R7: reset mid-run restores ascending order
    @(negedge clk);
    allRun(2'd1, 4'hF); grantTaken = 1'b1;
    @(negedge clk);
    grantTaken = 1'b0; rstN = 1'b0;
    #2; check("R7 reset again", grantValid, grantTid, 1'b1, 2'd0);
    @(negedge clk);
    rstN = 1'b1;
    headReady = 4'b1110;
    #2; check("R7 ascending next", grantValid, grantTid, 1'b1, 2'd1);

    // R9: single-thread configuration
    oneStatus = 3'd0; oneReady = 1'b0; oneEmpty = 1'b1;
    #2; check("R9 run not ready", oneValid, {1'b0, oneTid}, 1'b1, 2'd0);
    oneStatus = 3'd4;
    #2; check("R9 fetch trap", oneValid, {1'b0, oneTid}, 1'b1, 2'd0);
    oneStatus = 3'd2; oneReady = 1'b1; oneEmpty = 1'b0;
    #2; check("R9 squashing", oneValid, {1'b0, oneTid}, 1'b0, 2'd0);
    oneStatus = 3'd3;
    #2; check("R9 trap", oneValid, {1'b0, oneTid}, 1'b0, 2'd0);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule